// File: doc/BRIEF.md
# Dual-Clock Field Delay Memory

This block is a byte-wide serial memory that works as a programmable delay line between two unrelated clock domains. A writer pushes one word per enabled write-clock edge into consecutive locations. A reader pulls words from consecutive locations on its own clock. Each side keeps its own address pointer, and a sampled strobe returns that pointer to zero. The gap between the two streams is therefore fixed only by when the two strobes are issued relative to the data.

Each port has two separate controls. A "go" enable freezes the pointer when it is low. A second control leaves the pointer moving: on the write side it masks the store, so only chosen locations are overwritten, which is useful for inserting an inset picture. On the read side it blanks the output, so unwanted words can be skipped. The tri-state output is modelled as a data bus plus a drive flag. Each port also reports when its strobe is raised again before it has spent the required two cycles low.

Top module: `field_delay_mem`

## Requirements
- R1: A write-clock edge with `wr_zero` high sets the write pointer to 0 and stores nothing, whatever `wr_go` and `wr_store` are.
- R2: A read-clock edge with `rd_zero` high sets the read pointer to 0 and drops `rd_drive` to 0, whatever `rd_go` and `rd_show` are. The next enabled read then returns location 0.
- R3: With `wr_zero` low and `wr_go` high, a write edge stores `wr_data` (if `wr_store` is high) at the write pointer and advances the pointer by one. With `wr_go` low, the pointer holds and nothing is stored.
- R4: With `wr_go` high and `wr_store` low, the write pointer still advances, and the addressed location keeps its earlier contents.
- R5: With `rd_zero` low and `rd_go` high, a read edge loads the word at the read pointer and advances the pointer. With `rd_go` low, the pointer, `rd_data` and `rd_drive` all hold.
- R6: On an advancing read edge, `rd_drive` takes the value of `rd_show`. While `rd_drive` is 0, `rd_data` is all zeros. The pointer advances whether `rd_show` is high or low.
- R7: Each pointer wraps from DEPTH-1 to 0.
- R8: Data is returned unchanged in polarity and order. A read stream started by `rd_zero` returns the words written after `wr_zero`, so the delay equals the relative timing of the two strobes.
- R9: `wr_zero_err` (resp. `rd_zero_err`) is high for the single cycle after an edge where the strobe is sampled high following a low run of fewer than two cycles of its own clock. It is 0 otherwise.
- R10: During and after `rst_n` low, both pointers are 0, `rd_drive` is 0, `rd_data` is 0 and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| wr_clk | input | 1 | Write clock |
| wr_zero | input | 1 | Write pointer zeroing strobe |
| wr_go | input | 1 | Write pointer advance enable |
| wr_store | input | 1 | Write mask, 1 stores the word |
| wr_data | input | W | Input word |
| wr_zero_err | output | 1 | Write strobe spacing violation pulse |
| rd_clk | input | 1 | Read clock |
| rd_zero | input | 1 | Read pointer zeroing strobe |
| rd_go | input | 1 | Read pointer advance enable |
| rd_show | input | 1 | Output enable, 1 drives the word |
| rd_data | output | W | Output word, zero when not driven |
| rd_drive | output | 1 | Output drive flag |
| rd_zero_err | output | 1 | Read strobe spacing violation pulse |

## Verification
Suppose a pointer advances, freezes or zeroes incorrectly. A read stream then shows wrong words on the first advancing read edge that visits the affected address, one read cycle after that edge. A lost mask shows up as a changed old word when that location is next read. A bad spacing counter shows up as a wrong error flag one cycle after the strobe. Random go, mask and blank patterns are compared word by word against a bench memory model, across wraps and across two clocks that run at different rates.

// File: rtl/field_delay_mem.sv
module field_delay_mem #(
  parameter int DEPTH = 1024,
  parameter int W     = 8
) (
  input  logic         rst_n,
  input  logic         wr_clk,
  input  logic         wr_zero,
  input  logic         wr_go,
  input  logic         wr_store,
  input  logic [W-1:0] wr_data,
  output logic         wr_zero_err,
  input  logic         rd_clk,
  input  logic         rd_zero,
  input  logic         rd_go,
  input  logic         rd_show,
  output logic [W-1:0] rd_data,
  output logic         rd_drive,
  output logic         rd_zero_err
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [W-1:0]  rd_q;
  logic [1:0]    wlow, rlow;
  logic          wprev, rprev;

  wire w_step = !wr_zero && wr_go;
  wire r_step = !rd_zero && rd_go;

  // write side
  always_ff @(posedge wr_clk) begin
    if (rst_n && w_step && wr_store) mem[wptr] <= wr_data;
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) wptr <= '0;
    else if (wr_zero) wptr <= '0;
    else if (wr_go) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
  end

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wlow <= 2'd2;
      wprev <= 1'b0;
      wr_zero_err <= 1'b0;
    end else begin
      wr_zero_err <= wr_zero && !wprev && (wlow < 2'd2);
      wprev <= wr_zero;
      if (wr_zero) wlow <= 2'd0;
      else if (wlow != 2'd2) wlow <= wlow + 2'd1;
    end
  end

  // read side
  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      rd_q <= '0;
      rd_drive <= 1'b0;
    end else if (rd_zero) begin
      rptr <= '0;
      rd_drive <= 1'b0;
    end else if (rd_go) begin
      rd_q <= mem[rptr];
      rd_drive <= rd_show;
      rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
    end
  end

  assign rd_data = rd_drive ? rd_q : '0;

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rlow <= 2'd2;
      rprev <= 1'b0;
      rd_zero_err <= 1'b0;
    end else begin
      rd_zero_err <= rd_zero && !rprev && (rlow < 2'd2);
      rprev <= rd_zero;
      if (rd_zero) rlow <= 2'd0;
      else if (rlow != 2'd2) rlow <= rlow + 2'd1;
    end
  end

  a_r1_wr_zero: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_zero |=> (wptr == '0));
  a_r3_wr_hold: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!wr_zero && !wr_go) |=> $stable(wptr));
  a_r7_wr_wrap: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (w_step && wptr == LAST) |=> (wptr == '0));
  a_r9_wr_err: assert property (@(posedge wr_clk) disable iff (!rst_n)
    wr_zero_err |-> $past(wr_zero));
  a_r2_rd_zero: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_zero |=> (!rd_drive && rptr == '0));
  a_r5_rd_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!rd_zero && !rd_go) |=> ($stable(rd_data) && $stable(rd_drive) && $stable(rptr)));
  a_r6_rd_blank: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (r_step && !rd_show) |=> !rd_drive);
  a_r9_rd_err: assert property (@(posedge rd_clk) disable iff (!rst_n)
    rd_zero_err |-> $past(rd_zero));
endmodule

// File: tb/field_delay_mem_test.sv
module field_delay_mem_test;
  localparam int D = 64;

  logic rst_n = 1'b0, wclk = 1'b0, rclk = 1'b0;
  logic wr_zero = 0, wr_go = 0, wr_store = 0;
  logic [7:0] wr_data = '0;
  logic rd_zero = 0, rd_go = 0, rd_show = 0;
  logic [7:0] rd_data;
  logic rd_drive, wr_zero_err, rd_zero_err;

  always #2 wclk = ~wclk;
  always #3 rclk = ~rclk;

  field_delay_mem #(.DEPTH(D), .W(8)) uut (
    .rst_n(rst_n), .wr_clk(wclk), .wr_zero(wr_zero), .wr_go(wr_go),
    .wr_store(wr_store), .wr_data(wr_data), .wr_zero_err(wr_zero_err),
    .rd_clk(rclk), .rd_zero(rd_zero), .rd_go(rd_go), .rd_show(rd_show),
    .rd_data(rd_data), .rd_drive(rd_drive), .rd_zero_err(rd_zero_err));

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m [D];
  int wp = 0, rp = 0;
  logic [7:0] eq = 0;
  bit edrive = 0;
  int wlow = 2, rlow = 2;
  bit wprev = 0, rprev = 0;
  int wcnt = 0, rcnt = 0, wlast = 0, rlast = 0;

  always @(posedge wclk) wcnt++;
  always @(posedge rclk) rcnt++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit spacing_bad(input bit z, input bit prev, input int low);
    return z && !prev && (low < 2);
  endfunction

  // caller is at a write-clock negedge
  task automatic wr_cycle(input bit z, input bit g, input bit s, input logic [7:0] d);
    int n;
    bit ee;
    n = wcnt;
    if (n > wlast) begin wprev = 0; wlow = (wlow + n - wlast > 2) ? 2 : wlow + n - wlast; end
    wr_zero = z; wr_go = g; wr_store = s; wr_data = d;
    @(posedge wclk);
    wlast = n + 1;
    ee = spacing_bad(z, wprev, wlow);
    if (z) wlow = 0; else if (wlow < 2) wlow++;
    wprev = z;
    if (z) wp = 0;
    else if (g) begin
      if (s) m[wp] = d;
      wp = (wp + 1) % D;
    end
    @(negedge wclk);
    check(wr_zero_err == ee, "R9 write strobe spacing", wr_zero_err, ee);
  endtask

  task automatic rd_cycle(input bit z, input bit g, input bit s, input string tag);
    int n;
    bit ee;
    n = rcnt;
    if (n > rlast) begin rprev = 0; rlow = (rlow + n - rlast > 2) ? 2 : rlow + n - rlast; end
    rd_zero = z; rd_go = g; rd_show = s;
    @(posedge rclk);
    rlast = n + 1;
    ee = spacing_bad(z, rprev, rlow);
    if (z) rlow = 0; else if (rlow < 2) rlow++;
    rprev = z;
    if (z) begin rp = 0; edrive = 0; end
    else if (g) begin
      eq = m[rp];
      edrive = s;
      rp = (rp + 1) % D;
    end
    @(negedge rclk);
    check(rd_drive == edrive, {tag, " drive"}, rd_drive, edrive);
    check(rd_data == (edrive ? eq : 8'h00), {tag, " data"}, rd_data, edrive ? eq : 8'h00);
    check(rd_zero_err == ee, "R9 read strobe spacing", rd_zero_err, ee);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (4) @(negedge rclk);
    check(rd_drive == 0 && rd_data == 0, "R10 reset output", {rd_drive, rd_data}, 0);
    check(wr_zero_err == 0 && rd_zero_err == 0, "R10 reset flags", {wr_zero_err, rd_zero_err}, 0);
    rst_n = 1'b1;
    wlast = wcnt; rlast = rcnt;
    @(negedge wclk);

    // R1 strobe with enables high stores nothing, then fill with R3
    wr_cycle(1, 1, 1, 8'hA5);
    for (int k = 0; k < D; k++) wr_cycle(0, 1, 1, 8'(k) ^ 8'h3C);
    wr_cycle(0, 0, 1, 8'hFF);
    wr_cycle(0, 0, 0, 8'h00);

    // R2, R3 read back, R7 read wrap
    @(negedge rclk);
    rd_cycle(1, 1, 1, "R2 read strobe");
    for (int k = 0; k < D + 4; k++) rd_cycle(0, 1, 1, "R3 R7 sequential read");
    rd_cycle(0, 0, 0, "R5 hold");

    // R4 masked random writes with R7 write wrap
    @(negedge wclk);
    wr_cycle(1, 0, 0, 8'h00);
    for (int k = 0; k < 150; k++)
      wr_cycle(0, ($urandom % 4) != 0, ($urandom % 3) != 0, 8'($urandom));
    wr_cycle(0, 0, 0, 8'h00);

    // R5, R6 random go and blanking, R4 old contents seen
    @(negedge rclk);
    rd_cycle(1, 0, 1, "R2 read strobe");
    for (int k = 0; k < 200; k++)
      rd_cycle(0, ($urandom % 4) != 0, ($urandom % 3) != 0, "R4 R5 R6 random read");
    rd_cycle(0, 0, 0, "R5 hold");

    // R8 concurrent delayed stream
    fork
      begin
        @(negedge wclk);
        wr_cycle(1, 0, 0, 8'h00);
        for (int k = 0; k < 40; k++) wr_cycle(0, 1, 1, 8'($urandom));
        wr_cycle(0, 0, 0, 8'h00);
      end
      begin
        @(negedge rclk);
        repeat (3) rd_cycle(0, 0, 0, "R8 wait");
        rd_cycle(1, 0, 0, "R8 read strobe");
        for (int k = 0; k < 40; k++) rd_cycle(0, 1, 1, "R8 delayed stream");
        rd_cycle(0, 0, 0, "R8 idle");
      end
    join

    // R9 spacing violations
    @(negedge wclk);
    wr_cycle(0, 0, 0, 0); wr_cycle(0, 0, 0, 0);
    wr_cycle(1, 0, 0, 0); wr_cycle(0, 0, 0, 0); wr_cycle(1, 0, 0, 0);
    wr_cycle(0, 0, 0, 0); wr_cycle(0, 0, 0, 0); wr_cycle(1, 0, 0, 0);
    wr_cycle(0, 0, 0, 0);
    @(negedge rclk);
    rd_cycle(0, 0, 0, "R9 idle"); rd_cycle(0, 0, 0, "R9 idle");
    rd_cycle(1, 0, 0, "R9 strobe"); rd_cycle(0, 0, 0, "R9 gap");
    rd_cycle(1, 0, 0, "R9 early strobe"); rd_cycle(0, 0, 0, "R9 gap");
    rd_cycle(0, 0, 0, "R9 gap"); rd_cycle(1, 0, 0, "R9 legal strobe");
    rd_cycle(0, 1, 1, "R2 first word after strobe");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule